// File: doc/BRIEF.md
# Half-Band Interpolating/Decimating FIR Filter

This block is a fixed-coefficient, linear-phase half-band low-pass FIR filter with 55 taps. It accepts one 12-bit two's complement sample on every rising clock edge. It returns the full-precision filter sum on a wide signed output. A `valid_o` strobe is high after every edge on which the output register was loaded.

Two active-low mode pins select the operating mode:

- **Pass-through:** when both pins carry the same level, the filter runs at the input rate.
- **Interpolate:** every second input sample is replaced by zero before it enters the delay line. This halves the effective input rate and the gain.
- **Decimate:** the output register loads on only every second edge.

In both rate-changing modes a phase-set input aligns which edge counts as the data phase. The phase-set input has no effect in pass-through.

Rounding, saturation, output format conversion and bus driving belong to a following stage and are not part of this block.

Top module: `hb_fir`

## Requirements
- R1: While `rst_ni` is low, and until the first rising edge after it rises, `dout_o` is 0 and `valid_o` is 0. The delay line is cleared by reset, so a zero input after reset gives a zero output.
- R2: The coefficients are defined by d = |k-27| for k = 0..54. For d = 0 the coefficient is 16384. Every other even d has a coefficient of 0. For d = 1,3,5,...,27 the coefficients are 10398, -3379, 1926, -1272, 888, -631, 446, -309, 205, -128, 73, -35, 12, -1. A single nonzero sample x captured at edge E, with zeros before and after it in pass-through, gives `dout_o` = x*h[k] after edge E+7+k. The output is 0 after edges E+6 and E+62, and the peak x*16384 appears after edge E+34.
- R3: When `interp_ni` equals `decim_ni` (pass-through), `valid_o` is 1 after every edge and `phase_set_i` has no effect on `dout_o`.
- R4: In decimate mode (`decim_ni`=0, `interp_ni`=1), the output register loads only on edges where the newest sample in the result was captured on a data-phase edge. `valid_o` shows each load. `dout_o` holds its value on every other edge, so with steady phase the loads alternate.
- R5: In interpolate mode (`interp_ni`=0, `decim_ni`=1), a sample presented on a non-data-phase edge enters the filter as 0. `valid_o` is 1 after every edge.
- R6: If `phase_set_i` is 1 at edge N and 0 at edge N+1, then edge N+1 is a data-phase edge and the phase alternates from there. Toggling `phase_set_i` at half the clock rate keeps the same alignment.
- R7: Without such a high-then-low pattern, the data phase alternates freely on every edge. The first edge after reset is a data-phase edge.
- R8: A constant input x in pass-through settles to 32770*x. In interpolate mode with constant x, the settled output alternates between 16384*x and 16386*x.
- R9: `dout_o` is the exact filter sum, sign-extended to OUT_W bits. A full-scale constant input of -2048 settles to -67112960 and 2047 settles to 67080190.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; every register updates on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| interp_ni | input | 1 | Active-low interpolate select |
| decim_ni | input | 1 | Active-low decimate select |
| phase_set_i | input | 1 | Phase alignment for the rate-changing modes |
| din_i | input | DATA_W (12) | Two's complement input sample |
| dout_o | output | OUT_W (40) | Full-precision filter sum, sign-extended |
| valid_o | output | 1 | High after an edge that loaded dout_o |

## Verification
The test patterns and what each one checks:

- **Single impulse:** fixes the latency, the tap order and every coefficient value. Any register missing from or added to the pipeline, and any coefficient mix-up, shows up as a shift or a wrong value.
- **Constant full-scale inputs:** check the DC sum and show whether the accumulator has enough width.
- **Random data with phase-set toggling in pass-through:** shows whether the phase logic leaks into the pass-through mode.
- **Constant and random data in the two rate-changing modes:** first free-running, then aligned, then realigned in mid-stream. These patterns separate correct zero stuffing from a wrong phase, and correct alternate-edge loading from a wrong phase.

All cycles are compared against a sample-accurate convolution model.

// File: rtl/hb_pkg.sv
package hb_pkg;
  localparam int N_TAPS      = 55;
  localparam int CENTER      = (N_TAPS - 1) / 2;
  localparam int N_PAIRS     = (CENTER + 1) / 2;
  localparam int COEF_W      = 16;
  localparam int CENTER_COEF = 16384;

  // coefficient for offset 2p+1 from the centre tap
  function automatic logic signed [COEF_W-1:0] pair_coef(input int p);
    case (p)
      0:  return 16'sd10398;
      1:  return -16'sd3379;
      2:  return 16'sd1926;
      3:  return -16'sd1272;
      4:  return 16'sd888;
      5:  return -16'sd631;
      6:  return 16'sd446;
      7:  return -16'sd309;
      8:  return 16'sd205;
      9:  return -16'sd128;
      10: return 16'sd73;
      11: return -16'sd35;
      12: return 16'sd12;
      13: return -16'sd1;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/hb_phase.sv
module hb_phase #(
  parameter int DATA_W = 12
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     stuff_i,
  input  logic                     phase_set_i,
  input  logic signed [DATA_W-1:0] din_i,
  output logic signed [DATA_W-1:0] smp_o,
  output logic                     tag_o
);
  logic set_q;
  logic data_now;

  // plain history of the phase-set pin, reset-independent
  always_ff @(posedge clk_i) set_q <= phase_set_i;

  assign data_now = (set_q && !phase_set_i) ? 1'b1 : !tag_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_o <= '0;
      tag_o <= 1'b0;
    end else begin
      tag_o <= data_now;
      smp_o <= (stuff_i && !data_now) ? '0 : din_i;
    end
  end
endmodule

// File: rtl/hb_tapline.sv
module hb_tapline
  import hb_pkg::*;
#(
  parameter int DATA_W = 12,
  localparam int PRE_W = DATA_W + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [DATA_W-1:0] smp_i,
  output logic signed [PRE_W-1:0]  pre_o [N_PAIRS],
  output logic signed [DATA_W-1:0] ctr_o
);
  logic signed [DATA_W-1:0] dl_q [N_TAPS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_TAPS; i++) dl_q[i] <= '0;
    end else begin
      dl_q[0] <= smp_i;
      for (int i = 1; i < N_TAPS; i++) dl_q[i] <= dl_q[i-1];
    end
  end

  // symmetric pre-add; even offsets other than the centre are zero and skipped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < N_PAIRS; p++) pre_o[p] <= '0;
      ctr_o <= '0;
    end else begin
      for (int p = 0; p < N_PAIRS; p++)
        pre_o[p] <= PRE_W'(dl_q[CENTER-(2*p+1)]) + PRE_W'(dl_q[CENTER+2*p+1]);
      ctr_o <= dl_q[CENTER];
    end
  end
endmodule

// File: rtl/hb_mac.sv
module hb_mac
  import hb_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int ACC_W  = 33,
  parameter int ALIGN  = 2,
  localparam int PROD_W = DATA_W + 1 + COEF_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [DATA_W:0]   pre_i [N_PAIRS],
  input  logic signed [DATA_W-1:0] ctr_i,
  output logic signed [ACC_W-1:0]  acc_o
);
  localparam logic signed [COEF_W-1:0] CTR_C = COEF_W'(CENTER_COEF);

  logic signed [PROD_W-1:0] prod_q [N_PAIRS+1];
  logic signed [ACC_W-1:0]  sum_d;
  logic signed [ACC_W-1:0]  sum_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p <= N_PAIRS; p++) prod_q[p] <= '0;
    end else begin
      for (int p = 0; p < N_PAIRS; p++)
        prod_q[p] <= PROD_W'(pre_i[p]) * PROD_W'(pair_coef(p));
      prod_q[N_PAIRS] <= PROD_W'(ctr_i) * PROD_W'(CTR_C);
    end
  end

  always_comb begin
    sum_d = '0;
    for (int p = 0; p <= N_PAIRS; p++) sum_d = sum_d + ACC_W'(prod_q[p]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_q <= '0;
    else         sum_q <= sum_d;
  end

  generate
    if (ALIGN == 0) begin : g_noalign
      assign acc_o = sum_q;
    end else begin : g_align
      logic signed [ACC_W-1:0] al_q [ALIGN];
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int i = 0; i < ALIGN; i++) al_q[i] <= '0;
        end else begin
          al_q[0] <= sum_q;
          for (int i = 1; i < ALIGN; i++) al_q[i] <= al_q[i-1];
        end
      end
      assign acc_o = al_q[ALIGN-1];
    end
  endgenerate
endmodule

// File: rtl/hb_fir.sv
module hb_fir
  import hb_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int OUT_W     = 40,
  parameter int LAT_FIRST = 7
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     interp_ni,
  input  logic                     decim_ni,
  input  logic                     phase_set_i,
  input  logic signed [DATA_W-1:0] din_i,
  output logic signed [OUT_W-1:0]  dout_o,
  output logic                     valid_o
);
  localparam int ACC_W = DATA_W + 1 + COEF_W + $clog2(N_PAIRS + 1);
  // capture, tap, pre-add, product, sum registers precede the output register
  localparam int ALIGN = LAT_FIRST - 5;
  localparam int TAG_D = LAT_FIRST - 1;

  logic mode_int, mode_dec;
  logic signed [DATA_W-1:0] smp_q;
  logic tag_q;
  logic signed [DATA_W:0]   pre_q [N_PAIRS];
  logic signed [DATA_W-1:0] ctr_q;
  logic signed [ACC_W-1:0]  acc;
  logic [TAG_D-1:0]         tag_sr;
  logic                     upd;

  assign mode_int = !interp_ni && decim_ni;
  assign mode_dec = !decim_ni && interp_ni;

  hb_phase #(.DATA_W(DATA_W)) u_phase (
    .clk_i, .rst_ni, .stuff_i(mode_int), .phase_set_i,
    .din_i, .smp_o(smp_q), .tag_o(tag_q)
  );

  hb_tapline #(.DATA_W(DATA_W)) u_taps (
    .clk_i, .rst_ni, .smp_i(smp_q), .pre_o(pre_q), .ctr_o(ctr_q)
  );

  hb_mac #(.DATA_W(DATA_W), .ACC_W(ACC_W), .ALIGN(ALIGN)) u_mac (
    .clk_i, .rst_ni, .pre_i(pre_q), .ctr_i(ctr_q), .acc_o(acc)
  );

  // phase tag travels beside the newest sample
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tag_sr <= '0;
    else         tag_sr <= {tag_sr[TAG_D-2:0], tag_q};
  end

  assign upd = !mode_dec || tag_sr[TAG_D-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= upd;
      if (upd) dout_o <= OUT_W'(acc);
    end
  end
endmodule

// File: rtl/hb_fir_chk.sv
module hb_fir_chk #(
  parameter int OUT_W = 40
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             interp_ni,
  input logic             decim_ni,
  input logic             phase_set_i,
  input logic             tag_i,
  input logic             valid_o,
  input logic [OUT_W-1:0] dout_o
);
  logic set_q;
  always_ff @(posedge clk_i) set_q <= phase_set_i;

  // R3: outside decimate mode every edge loads the output
  a_r3_every_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!decim_ni && interp_ni) |=> valid_o);

  // R4: no load means the output holds
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(dout_o));

  // R6: high-then-low on phase_set_i marks a data-phase edge
  a_r6_sync_align: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_q && !phase_set_i && (interp_ni != decim_ni)) |=> tag_i);

  // R7: without alignment the phase alternates
  a_r7_free_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_q && !phase_set_i) |=> (tag_i != $past(tag_i)));
endmodule

bind hb_fir hb_fir_chk #(.OUT_W(OUT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .interp_ni(interp_ni), .decim_ni(decim_ni),
  .phase_set_i(phase_set_i), .tag_i(tag_q), .valid_o(valid_o), .dout_o(dout_o)
);

// File: tb/sim_hb_fir.sv
module sim_hb_fir;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic int_n = 1'b1, dec_n = 1'b1, pset = 1'b0;
  logic signed [11:0] din = '0;
  logic signed [39:0] dout;
  logic valid;

  always #4 clk = ~clk;

  hb_fir u0 (
    .clk_i(clk), .rst_ni(rst_n), .interp_ni(int_n), .decim_ni(dec_n),
    .phase_set_i(pset), .din_i(din), .dout_o(dout), .valid_o(valid)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  longint hist [64];
  bit     tagh [64];
  int     n;
  bit     ph, sprev;
  longint exp_out;
  bit     exp_valid;

  function automatic longint hcoef(input int k);
    int d;
    d = (k > 27) ? k - 27 : 27 - k;
    if (d == 0) return 16384;
    case (d)
      1: return 10398;  3: return -3379;  5: return 1926;  7: return -1272;
      9: return 888;   11: return -631;  13: return 446;  15: return -309;
      17: return 205;  19: return -128;  21: return 73;   23: return -35;
      25: return 12;   27: return -1;
      default: return 0;
    endcase
  endfunction

  function automatic longint hget(input int i);
    return (i >= 1) ? hist[i % 64] : 0;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 64; i++) begin hist[i] = 0; tagh[i] = 1'b0; end
    n = 0; ph = 1'b0; sprev = 1'b0; exp_out = 0; exp_valid = 1'b0;
  endtask

  task automatic model_edge(input longint x, input bit s);
    bit fall, data, interp, decm, upd;
    longint acc;
    fall = sprev && !s;
    data = fall ? 1'b1 : !ph;
    ph = data; sprev = s;
    interp = !int_n && dec_n;
    decm = !dec_n && int_n;
    n++;
    hist[n % 64] = (interp && !data) ? 0 : x;
    tagh[n % 64] = data;
    upd = !decm || ((n - 7 >= 1) ? tagh[(n - 7) % 64] : 1'b0);
    acc = 0;
    for (int k = 0; k < 55; k++) acc += hcoef(k) * hget(n - 7 - k);
    exp_valid = upd;
    if (upd) exp_out = acc;
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic step(input longint x, input bit s, input string req);
    din = 12'(x); pset = s;
    @(posedge clk);
    model_edge(x, s);
    @(negedge clk);
    chk(longint'(dout) == exp_out, req, longint'(dout), exp_out);
    chk(valid == exp_valid, req, longint'(valid), longint'(exp_valid));
  endtask

  task automatic do_reset();
    rst_n = 1'b0; din = '0; pset = 1'b0;
    repeat (3) @(negedge clk);
    model_reset();
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    int_n = 1'b1; dec_n = 1'b1;
    do_reset();
    chk(dout == 0, "R1 dout after reset", longint'(dout), 0);
    chk(valid == 1'b0, "R1 valid after reset", longint'(valid), 0);
    for (int i = 0; i < 10; i++) step(0, 1'b0, "R1 zero input");
  endtask

  task automatic t_impulse();
    int_n = 1'b1; dec_n = 1'b1;
    do_reset();
    step(1000, 1'b0, "R2 impulse");
    for (int i = 1; i <= 70; i++) begin
      step(0, 1'b0, "R2 response");
      if (i == 6)  chk(dout == 0, "R2 before start", longint'(dout), 0);
      if (i == 7)  chk(longint'(dout) == -1000, "R2 first tap", longint'(dout), -1000);
      if (i == 8)  chk(dout == 0, "R2 zero even tap", longint'(dout), 0);
      if (i == 33) chk(longint'(dout) == 10398000, "R2 tap 26", longint'(dout), 10398000);
      if (i == 34) chk(longint'(dout) == 16384000, "R2 peak", longint'(dout), 16384000);
      if (i == 61) chk(longint'(dout) == -1000, "R2 last tap", longint'(dout), -1000);
      if (i == 62) chk(dout == 0, "R2 after end", longint'(dout), 0);
    end
  endtask

  task automatic t_pass();
    int_n = 1'b1; dec_n = 1'b1;
    for (int i = 0; i < 60; i++) step($urandom_range(4095) - 2048, 1'(i % 2), "R3 pass high pins");
    int_n = 1'b0; dec_n = 1'b0;
    for (int i = 0; i < 60; i++) step($urandom_range(4095) - 2048, 1'($urandom_range(1)), "R3 pass low pins");
    chk(valid == 1'b1, "R3 valid", longint'(valid), 1);
  endtask

  task automatic t_dc();
    int_n = 1'b1; dec_n = 1'b1;
    for (int i = 0; i < 70; i++) step(-2048, 1'b0, "R9 negative full scale");
    chk(longint'(dout) == -67112960, "R9 negative sum", longint'(dout), -67112960);
    for (int i = 0; i < 70; i++) step(2047, 1'b0, "R9 positive full scale");
    chk(longint'(dout) == 67080190, "R9 positive sum", longint'(dout), 67080190);
    for (int i = 0; i < 70; i++) step(1000, 1'b0, "R8 constant");
    chk(longint'(dout) == 32770000, "R8 pass gain", longint'(dout), 32770000);
  endtask

  task automatic t_free();
    longint a;
    int_n = 1'b0; dec_n = 1'b1;
    do_reset();
    step(500, 1'b0, "R7 first edge data");
    step(700, 1'b0, "R7 second edge zeroed");
    for (int i = 3; i <= 40; i++) begin
      step(0, 1'b0, "R7 free run");
      if (i == 35) chk(longint'(dout) == 8192000, "R7 data peak", longint'(dout), 8192000);
      if (i == 36) begin
        a = 500 * 10398;
        chk(longint'(dout) == a, "R7 stuffed sample", longint'(dout), a);
      end
    end
  endtask

  task automatic t_interp();
    longint a, b;
    int_n = 1'b0; dec_n = 1'b1;
    step(0, 1'b1, "R6 set high");
    step(1000, 1'b0, "R6 first data");
    for (int i = 0; i < 80; i++) step(1000, 1'b0, "R5 constant");
    a = longint'(dout);
    step(1000, 1'b0, "R5 constant");
    b = longint'(dout);
    chk(a + b == 32770000, "R8 interp pair sum", a + b, 32770000);
    chk(a == 16384000 || b == 16384000, "R8 interp centre phase", a, 16384000);
    for (int i = 0; i < 40; i++) step($urandom_range(4095) - 2048, 1'(i % 2 == 0), "R6 half-rate toggle");
    step(300, 1'b1, "R6 realign high");
    step(300, 1'b1, "R6 realign hold");
    step(-900, 1'b0, "R6 realign low");
    for (int i = 0; i < 70; i++) step($urandom_range(4095) - 2048, 1'b0, "R5 random");
  endtask

  task automatic t_decim();
    int cnt;
    int_n = 1'b1; dec_n = 1'b0;
    step(0, 1'b1, "R6 dec set high");
    for (int i = 0; i < 40; i++) step($urandom_range(4095) - 2048, 1'b0, "R4 decimate");
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      step($urandom_range(4095) - 2048, 1'b0, "R4 decimate");
      cnt += int'(valid);
    end
    chk(cnt == 10, "R4 load count", cnt, 10);
    step(0, 1'b1, "R6 dec realign");
    step(0, 1'b1, "R6 dec realign");
    for (int i = 0; i < 60; i++) step($urandom_range(4095) - 2048, 1'b0, "R4 after realign");
    for (int i = 0; i < 30; i++) step(1000, 1'(i % 2), "R4 toggled set");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_impulse();
    t_pass();
    t_dc();
    t_free();
    t_interp();
    t_decim();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule